// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Channel

This block is one full-duplex asynchronous serial channel with a small register file. Each direction has two stages. A shift engine that software cannot reach does the bit-level work, and an 8-bit holding register sits in front of it for software. Transmit data written to the holding register moves into the shifter as soon as the shifter is free, so frames can go out back to back. A received frame is copied into the receive holding register as soon as its first stop bit has been sampled.

A programmable divider runs from the peripheral clock and produces a tick at sixteen times the bit rate. One bit lasts (DIV+1)×16 clocks. The receiver looks for a low level on the resynchronised line. It confirms the start bit near its middle and then samples every later bit at its centre.

Five status flags can be read by software and cleared by software, but never set by software: transmit buffer empty, receive full, overrun, framing error and parity error. A sixth bit, transmit end, is read-only.

Top module: `udc_serial_chan`

## Requirements
- R1: After reset, `txd` is 1, the status register reads 8'h84, and both directions are disabled.
- R2: Register map on `reg_addr`, with `reg_wr` writing `reg_wdata` and `reg_rdata` returning the addressed register combinationally:
  - 0: format. Bit 0 selects 7 data bits, bit 1 enables parity, bit 2 selects odd parity, bit 3 selects two stop bits, bit 4 selects MSB-first.
  - 1: control. Bit 0 enables transmit, bit 1 enables receive.
  - 2: divider.
  - 3: transmit holding register.
  - 4: receive holding register, read-only.
  - 5: status. Bit 7 transmit empty, bit 6 receive full, bit 5 overrun, bit 4 framing error, bit 3 parity error, bit 2 transmit end.
- R3: A transmitted frame has these parts, each lasting (DIV+1)×16 clocks: a start bit of 0, then the data bits, then a parity bit if enabled (even or odd, taken over the data bits), then one or two stop bits of 1. The line is 1 when idle.
- R4: With 8 data bits, format bit 4 selects MSB-first. With 7 data bits, the order is always LSB-first and data bit 7 is ignored. The same rules apply to transmit and receive.
- R5: Writing the transmit holding register clears transmit empty. The flag sets again when the contents move into the shifter. A second byte written during a frame is sent right after it.
- R6: Transmit end reads 1 exactly when transmit empty is 1 and no frame is being shifted.
- R7: A frame received while receive is enabled is placed in the receive holding register, and receive full is set.
- R8: If a frame completes while receive full is 1, overrun is set and the receive holding register keeps its old value.
- R9: If the first stop bit samples as 0, framing error is set.
- R10: With parity enabled, a received parity bit that does not match the selected sense sets parity error. A matching parity bit leaves the flag clear.
- R11: Writing a 0 to status bits 7..3 clears them. Writing a 1 leaves them unchanged.
- R12: While transmit is disabled, a pending byte is held and `txd` stays 1. While receive is disabled, incoming frames change neither the flags nor the receive holding register.
- R13: A low pulse on `rxd` shorter than about half a bit is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | peripheral clock |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_addr | input | 3 | register select |
| reg_wr | input | 1 | register write strobe |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data of the addressed register |
| rxd | input | 1 | serial receive line |
| txd | output | 1 | serial transmit line |

## Verification
The assertions assume that the format and divider stay unchanged while a frame is being shifted or received. They also assume that the status register is not written on the same cycle that a frame completes. The stimulus meets both conditions. It reprograms the channel only after transmit end reads 1 and the receive line has been idle for a full bit. It drives every receive frame at exactly the programmed bit time. It clears flags only between frames, always writing 1 to the transmit-empty bit so that no stale byte is released.

// File: rtl/udc_pkg.sv
package udc_pkg;

   localparam int FRAME_MAX = 12;

   localparam logic [2:0] A_FMT = 3'd0;
   localparam logic [2:0] A_CTL = 3'd1;
   localparam logic [2:0] A_DIV = 3'd2;
   localparam logic [2:0] A_TXB = 3'd3;
   localparam logic [2:0] A_RXB = 3'd4;
   localparam logic [2:0] A_STS = 3'd5;

   typedef struct packed {
      logic msb_first;
      logic stop2;
      logic par_odd;
      logic par_en;
      logic len7;
   } fmt_t;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_HOLD
   } rx_state_t;

   function automatic logic calc_parity(input logic [7:0] d, input fmt_t f);
      logic [7:0] m;
      m = f.len7 ? 8'h7F : 8'hFF;
      return (^(d & m)) ^ f.par_odd;
   endfunction

endpackage

// File: rtl/udc_baud.sv
module udc_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= div) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && $stable(div)) |-> (cnt <= div));

endmodule

// File: rtl/udc_tx_shift.sv
module udc_tx_shift
   import udc_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       enable,
   input  logic       pending,
   input  fmt_t       fmt,
   input  logic [7:0] din,
   output logic       take,
   output logic       busy,
   output logic       txd
);

   localparam int TW = $clog2(OVS);
   localparam logic [TW-1:0] TLAST = TW'(OVS - 1);

   logic [FRAME_MAX-1:0] frm;
   logic [FRAME_MAX-1:0] shreg;
   logic [3:0]           flen;
   logic [3:0]           len_q;
   logic [3:0]           bidx;
   logic [TW-1:0]        tcnt;

   always_comb begin
      frm    = '1;
      frm[0] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i < (fmt.len7 ? 7 : 8))
            frm[1+i] = (fmt.msb_first && !fmt.len7) ? din[7-i] : din[i];
      end
      if (fmt.par_en) begin
         if (fmt.len7) frm[8] = calc_parity(din, fmt);
         else          frm[9] = calc_parity(din, fmt);
      end
      flen = 4'd10 - {3'b0, fmt.len7} + {3'b0, fmt.par_en} + {3'b0, fmt.stop2};
   end

   assign take = enable && pending && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         txd   <= 1'b1;
         shreg <= '1;
         len_q <= '0;
         bidx  <= '0;
         tcnt  <= '0;
      end else if (take) begin
         busy  <= 1'b1;
         txd   <= 1'b0;
         shreg <= frm;
         len_q <= flen;
         bidx  <= '0;
         tcnt  <= '0;
      end else if (busy && tick) begin
         if (tcnt == TLAST) begin
            tcnt <= '0;
            if (bidx == len_q - 4'd1) begin
               busy <= 1'b0;
               txd  <= 1'b1;
            end else begin
               bidx  <= bidx + 4'd1;
               txd   <= shreg[1];
               shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
            end
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);

   assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   assert_hold_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !busy) |=> !busy);

endmodule

// File: rtl/udc_rx_shift.sv
module udc_rx_shift
   import udc_pkg::*;
#(
   parameter int OVS  = 16,
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       enable,
   input  logic       rxd,
   input  fmt_t       fmt,
   output logic       done,
   output logic [7:0] dout,
   output logic       stop_bad,
   output logic       par_bad
);

   localparam int TW = $clog2(OVS);
   localparam logic [TW-1:0] TLAST = TW'(OVS - 1);
   localparam logic [TW-1:0] TMID  = TW'(OVS / 2 - 2);

   logic sy [SYNC];

   genvar g;
   generate
      for (g = 0; g < SYNC; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sy[0] <= 1'b1;
               else        sy[0] <= rxd;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sy[g] <= 1'b1;
               else        sy[g] <= sy[g-1];
            end
         end
      end
   endgenerate

   logic       line;
   rx_state_t  st;
   logic [TW-1:0] tcnt;
   logic [3:0] bcnt;
   logic [7:0] sh;
   logic [7:0] word;
   logic       pbit;
   logic       msb8;
   logic       last_bit;

   assign line     = sy[SYNC-1];
   assign msb8     = fmt.msb_first && !fmt.len7;
   assign last_bit = (bcnt == (fmt.len7 ? 4'd6 : 4'd7));
   assign word     = fmt.len7 ? {1'b0, sh[7:1]} : sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= RX_IDLE;
         tcnt     <= '0;
         bcnt     <= '0;
         sh       <= '0;
         pbit     <= 1'b0;
         done     <= 1'b0;
         dout     <= '0;
         stop_bad <= 1'b0;
         par_bad  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!enable) begin
            st <= RX_IDLE;
         end else begin
            case (st)
               RX_IDLE: begin
                  if (tick && !line) begin
                     st   <= RX_START;
                     tcnt <= '0;
                  end
               end
               RX_START: begin
                  if (tick) begin
                     if (tcnt == TMID) begin
                        tcnt <= '0;
                        bcnt <= '0;
                        st   <= line ? RX_IDLE : RX_DATA;
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               RX_DATA: begin
                  if (tick) begin
                     if (tcnt == TLAST) begin
                        tcnt <= '0;
                        if (msb8) sh <= {sh[6:0], line};
                        else      sh <= {line, sh[7:1]};
                        bcnt <= bcnt + 4'd1;
                        if (last_bit) st <= fmt.par_en ? RX_PAR : RX_STOP;
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               RX_PAR: begin
                  if (tick) begin
                     if (tcnt == TLAST) begin
                        tcnt <= '0;
                        pbit <= line;
                        st   <= RX_STOP;
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               RX_STOP: begin
                  if (tick) begin
                     if (tcnt == TLAST) begin
                        tcnt     <= '0;
                        done     <= 1'b1;
                        dout     <= word;
                        stop_bad <= !line;
                        par_bad  <= fmt.par_en && (pbit != calc_parity(word, fmt));
                        st       <= line ? RX_IDLE : RX_HOLD;
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               RX_HOLD: begin
                  if (line) st <= RX_IDLE;
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_no_rx_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !done);

endmodule

// File: rtl/udc_serial_chan.sv
module udc_serial_chan
   import udc_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] reg_addr,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       rxd,
   output logic       txd
);

   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W must be 1..8");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   fmt_t             fmt_q;
   logic [1:0]       ctl_q;
   logic [DIV_W-1:0] div_q;
   logic [7:0]       txbuf;
   logic [7:0]       rxbuf;
   logic             txe, rxf, ovr, frm_err, par_err;
   logic             tend;

   logic             tick;
   logic             tx_take, tx_busy;
   logic             rx_done, rx_stop_bad, rx_par_bad;
   logic [7:0]       rx_word;

   logic             wr_sts, wr_txb;

   assign wr_sts = reg_wr && (reg_addr == A_STS);
   assign wr_txb = reg_wr && (reg_addr == A_TXB);
   assign tend   = txe && !tx_busy;

   udc_baud #(.DIV_W(DIV_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .div  (div_q),
      .tick (tick)
   );

   udc_tx_shift #(.OVS(OVS)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .enable (ctl_q[0]),
      .pending(!txe),
      .fmt    (fmt_q),
      .din    (txbuf),
      .take   (tx_take),
      .busy   (tx_busy),
      .txd    (txd)
   );

   udc_rx_shift #(.OVS(OVS), .SYNC(SYNC_STAGES)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .enable  (ctl_q[1]),
      .rxd     (rxd),
      .fmt     (fmt_q),
      .done    (rx_done),
      .dout    (rx_word),
      .stop_bad(rx_stop_bad),
      .par_bad (rx_par_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q <= '0;
         ctl_q <= '0;
         div_q <= '0;
         txbuf <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_FMT:   fmt_q <= fmt_t'(reg_wdata[4:0]);
            A_CTL:   ctl_q <= reg_wdata[1:0];
            A_DIV:   div_q <= reg_wdata[DIV_W-1:0];
            A_TXB:   txbuf <= reg_wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txe     <= 1'b1;
         rxf     <= 1'b0;
         ovr     <= 1'b0;
         frm_err <= 1'b0;
         par_err <= 1'b0;
         rxbuf   <= '0;
      end else begin
         if (wr_sts) begin
            txe     <= txe     & reg_wdata[7];
            rxf     <= rxf     & reg_wdata[6];
            ovr     <= ovr     & reg_wdata[5];
            frm_err <= frm_err & reg_wdata[4];
            par_err <= par_err & reg_wdata[3];
         end
         if (tx_take) txe <= 1'b1;
         if (wr_txb)  txe <= 1'b0;
         if (rx_done && ctl_q[1]) begin
            if (rxf) begin
               ovr <= 1'b1;
            end else begin
               rxbuf <= rx_word;
               rxf   <= 1'b1;
               if (rx_stop_bad) frm_err <= 1'b1;
               if (rx_par_bad)  par_err <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      case (reg_addr)
         A_FMT:   reg_rdata = {3'b000, fmt_q};
         A_CTL:   reg_rdata = {6'b0, ctl_q};
         A_DIV:   reg_rdata = 8'(div_q);
         A_TXB:   reg_rdata = txbuf;
         A_RXB:   reg_rdata = rxbuf;
         A_STS:   reg_rdata = {txe, rxf, ovr, frm_err, par_err, tend, 2'b00};
         default: reg_rdata = 8'h00;
      endcase
   end

   assert_txe_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txe) |-> $past(tx_take));

   assert_rxf_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxf) |-> $past(rx_done && ctl_q[1]));

   assert_ovr_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(rx_done && rxf));

   assert_rxbuf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rxf) |=> $stable(rxbuf));

   assert_frm_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_err) |-> $past(rx_done && rx_stop_bad));

   assert_par_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_err) |-> $past(rx_done && rx_par_bad));

   assert_no_sw_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && !rx_done && !tx_take) |=>
         !($rose(rxf) || $rose(ovr) || $rose(frm_err) || $rose(par_err) || $rose(txe)));

   assert_tend_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !tend);

endmodule

// File: tb/tb_udc_serial_chan.sv
module tb_udc_serial_chan;

   localparam int CLK_PERIOD = 10;
   localparam int DIVV = 3;
   localparam int BIT  = (DIVV + 1) * 16;

   localparam logic [2:0] FMT = 3'd0;
   localparam logic [2:0] CTL = 3'd1;
   localparam logic [2:0] DIV = 3'd2;
   localparam logic [2:0] TXB = 3'd3;
   localparam logic [2:0] RXB = 3'd4;
   localparam logic [2:0] STS = 3'd5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       rxd = 1'b1;
   logic       txd;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] expq[$];
   logic [4:0]  cur_fmt = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   udc_serial_chan dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .rxd      (rxd),
      .txd      (txd)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [15:0] mkframe(input logic [7:0] d, input logic [4:0] f);
      logic [11:0] b;
      logic p;
      int n;
      int k;
      b    = '1;
      b[0] = 1'b0;
      n    = f[0] ? 7 : 8;
      p    = f[2];
      for (int i = 0; i < n; i++) begin
         b[1+i] = (f[4] && !f[0]) ? d[7-i] : d[i];
         p ^= d[i];
      end
      k = 1 + n;
      if (f[1]) begin
         b[k] = p;
         k++;
      end
      k++;
      if (f[3]) k++;
      return {4'(k), b};
   endfunction

   task automatic send_tx(input logic [7:0] d);
      expq.push_back(mkframe(d, cur_fmt));
      wr(TXB, d);
   endtask

   task automatic set_fmt(input logic [4:0] f);
      cur_fmt = f;
      wr(FMT, {3'b000, f});
   endtask

   task automatic wait_tend();
      logic [7:0] s;
      for (int i = 0; i < 60 * BIT; i++) begin
         rd(STS, s);
         if (s[2]) break;
      end
      chk("R6 transmit end after frames", {15'b0, s[2]}, 16'h1);
   endtask

   task automatic drive_rx(input logic [15:0] fr);
      for (int i = 0; i < int'(fr[15:12]); i++) begin
         rxd = fr[i];
         repeat (BIT) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (BIT) @(negedge clk);
   endtask

   // scoreboard monitor: decodes txd and compares against queued frames
   initial begin : mon
      forever begin : one
         logic [15:0] e;
         logic [11:0] got;
         int len;
         @(negedge txd);
         if (expq.size() == 0) begin
            chk("R3 unexpected frame on txd", 16'h1, 16'h0);
            continue;
         end
         e   = expq.pop_front();
         len = int'(e[15:12]);
         got = '1;
         repeat (BIT/2) @(negedge clk);
         got[0] = txd;
         for (int i = 1; i < len; i++) begin
            repeat (BIT) @(negedge clk);
            got[i] = txd;
         end
         chk("R3/R4/R5 tx frame", {4'(len), got}, e);
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] s;
      logic [7:0] d;
      bit line_ok;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 txd idle", {15'b0, txd}, 16'h1);
      rd(STS, s);
      chk("R1 status after reset", {8'h0, s}, 16'h0084);
      rd(CTL, s);
      chk("R1 control after reset", {8'h0, s}, 16'h0000);

      set_fmt(5'h00);
      wr(DIV, 8'(DIVV));
      rd(DIV, s);
      chk("R2 divider readback", {8'h0, s}, 16'(DIVV));
      wr(CTL, 8'h03);

      // R3 single 8N1 frame
      send_tx(8'hA5);
      wait_tend();

      // R5 double buffering, R6 transmit end low while pending
      send_tx(8'h3C);
      repeat (4) @(negedge clk);
      send_tx(8'h5A);
      rd(STS, s);
      chk("R5 empty clear with byte pending", {8'h0, s & 8'h84}, 16'h0000);
      wait_tend();

      // R4 MSB-first with even parity
      set_fmt(5'h12);
      send_tx(8'h81);
      wait_tend();
      // R3 odd parity, two stop bits
      set_fmt(5'h0E);
      send_tx(8'h7E);
      wait_tend();
      // R4 seven bits with MSB-first requested: sent LSB-first, bit 7 ignored
      set_fmt(5'h11);
      send_tx(8'hAB);
      wait_tend();

      // R12 transmit disabled holds the byte
      set_fmt(5'h00);
      wr(CTL, 8'h02);
      wr(TXB, 8'h77);
      line_ok = 1'b1;
      for (int i = 0; i < 3 * BIT; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) line_ok = 1'b0;
      end
      chk("R12 txd idle while disabled", {15'b0, line_ok}, 16'h1);
      rd(STS, s);
      chk("R12 byte still pending", {15'b0, s[7]}, 16'h0);
      expq.push_back(mkframe(8'h77, cur_fmt));
      wr(CTL, 8'h03);
      wait_tend();
      repeat (BIT) @(negedge clk);
      chk("R5 all queued frames sent", 16'(expq.size()), 16'h0);

      // R7 receive
      drive_rx(mkframe(8'h6B, 5'h00));
      rd(RXB, s);
      chk("R7 receive data", {8'h0, s}, 16'h006B);
      rd(STS, s);
      chk("R7 receive full", {8'h0, s}, 16'h00C4);

      // R8 overrun
      drive_rx(mkframe(8'h11, 5'h00));
      rd(RXB, s);
      chk("R8 data kept on overrun", {8'h0, s}, 16'h006B);
      rd(STS, s);
      chk("R8 overrun flag", {8'h0, s}, 16'h00E4);

      // R11 clear by writing 0, writing 1 never sets
      wr(STS, 8'h80);
      rd(STS, s);
      chk("R11 flags cleared", {8'h0, s}, 16'h0084);
      wr(STS, 8'hFF);
      rd(STS, s);
      chk("R11 write of ones sets nothing", {8'h0, s}, 16'h0084);

      // R9 framing error: stop bit (index 9) driven low
      drive_rx(mkframe(8'h55, 5'h00) ^ 16'h0200);
      rd(STS, s);
      chk("R9 framing error", {8'h0, s}, 16'h00D4);
      wr(STS, 8'h80);

      // R10 parity, even sense: good then bad (parity at index 9)
      set_fmt(5'h02);
      drive_rx(mkframe(8'h0F, 5'h02));
      rd(STS, s);
      chk("R10 good parity no error", {8'h0, s}, 16'h00C4);
      wr(STS, 8'h80);
      drive_rx(mkframe(8'h0F, 5'h02) ^ 16'h0200);
      rd(STS, s);
      chk("R10 bad parity flagged", {8'h0, s}, 16'h00CC);
      wr(STS, 8'h80);

      // R4 receive MSB-first 8-bit
      set_fmt(5'h10);
      drive_rx(mkframe(8'hC1, 5'h10));
      rd(RXB, s);
      chk("R4 msb-first receive", {8'h0, s}, 16'h00C1);
      wr(STS, 8'h80);
      // R4 receive 7-bit, MSB-first request ignored
      set_fmt(5'h11);
      drive_rx(mkframe(8'h35, 5'h11));
      rd(RXB, s);
      chk("R4 7-bit receive lsb-first", {8'h0, s}, 16'h0035);
      wr(STS, 8'h80);

      // R12 receive disabled
      set_fmt(5'h00);
      wr(CTL, 8'h01);
      drive_rx(mkframe(8'h99, 5'h00));
      rd(STS, s);
      chk("R12 no flags while rx disabled", {8'h0, s}, 16'h0084);
      rd(RXB, s);
      chk("R12 rx data unchanged", {8'h0, s}, 16'h0035);
      wr(CTL, 8'h03);

      // R13 short low glitch rejected
      rxd = 1'b0;
      repeat (BIT/4) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * BIT) @(negedge clk);
      rd(STS, s);
      chk("R13 glitch ignored", {8'h0, s}, 16'h0084);
      drive_rx(mkframe(8'h42, 5'h00));
      rd(RXB, d);
      chk("R13 frame after glitch", {8'h0, d}, 16'h0042);
      rd(STS, s);
      chk("R7 full after glitch frame", {8'h0, s}, 16'h00C4);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule